// File: doc/BRIEF.md
# Eight-Phase Control Sequencer

This block is the control unit of a small bus-structured accumulator machine with four instructions: NOR, ADD, store and conditional jump. A phase counter steps through eight phases, one per rising clock edge, and wraps from 7 back to 0. For each phase it looks at the 2-bit instruction code and the carry flag and produces registered strobes for the datapath. These are output and write enables for memory, the address register, the instruction register, the program counter, the accumulator and the ALU. It also produces a program-counter increment pulse, a program-counter load, a carry-clear strobe for the accumulator and the ALU function select.

Phases 0 to 3 fetch the instruction and its operand address, with the program counter driving the address. Phases 4 to 7 execute, with the address register and the instruction register driving. The strobes are registered. The values visible while the counter shows phase P were decoded from P and from the instruction code and carry present at the clock edge that entered P. The block also forms an immediate byte from the low nibble of the held instruction, and presents it only while the instruction register drives the bus.

Top module: `ctl_phase_seq`

## Requirements
- R1: `phase` increments by one, modulo 8, on every rising clock edge while `rst` is low. A synchronous `rst` high at an edge returns it to 0.
- R2: After an edge with `rst` high, every strobe output and `alu_fn` are 0.
- R3: `pc_oe` is 1 in phases 0–3 and 0 otherwise. `ar_oe` and `ir_oe` are 1 in phases 4–7 and 0 otherwise.
- R4: `ram_oe` is 1 in phases 0–3. For codes 2'b00 (NOR) and 2'b01 (ADD) it is also 1 in phases 4 and 5. Otherwise it is 0.
- R5: `ir_we` is 1 only in phase 1, `ar_we` only in phase 3, and `pc_inc` only in phases 2 and 4, for every code.
- R6: For codes 2'b00 and 2'b01, `alu_we` is 1 in phase 5, `alu_oe` in phases 5 and 6, and `acc_we` in phase 6. For the other codes all three are 0.
- R7: `alu_fn` equals bit 0 of the instruction code, where 0 selects NOR and 1 selects ADD.
- R8: For code 2'b10 (store), `acc_oe` is 1 in phases 5 and 6 and `ram_we` is 1 in phase 6. For all other codes both are 0.
- R9: For code 2'b11 (jump) in phase 5, `pc_load` is 1 when carry is 0 and `acc_carry_clr` is 1 when carry is 1. Both are 0 in every other case.
- R10: `imm_byte` is `{ir_nibble, ir_nibble}` while `ir_oe` is 1, and 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 2 | Instruction code: 00 NOR, 01 ADD, 10 store, 11 jump |
| carry_in | input | 1 | Accumulator carry flag |
| ir_nibble | input | 4 | Low nibble of the held instruction |
| phase | output | 3 | Current phase |
| ram_oe | output | 1 | Memory output enable |
| ram_we | output | 1 | Memory write enable |
| pc_oe | output | 1 | Program counter drives address |
| pc_load | output | 1 | Program counter load (jump taken) |
| pc_inc | output | 1 | Program counter increment pulse |
| ar_oe | output | 1 | Address register drives address |
| ar_we | output | 1 | Address register write |
| ir_oe | output | 1 | Instruction register drives |
| ir_we | output | 1 | Instruction register write |
| acc_oe | output | 1 | Accumulator drives data bus |
| acc_we | output | 1 | Accumulator write |
| acc_carry_clr | output | 1 | Accumulator carry clear |
| alu_oe | output | 1 | ALU result drives |
| alu_we | output | 1 | ALU operand latch |
| alu_fn | output | 1 | ALU function: 0 NOR, 1 ADD |
| imm_byte | output | 8 | Replicated immediate byte |

## Verification
Two functions share a cycle in phase 6. For NOR and ADD, the ALU drives its result in the same phase that the accumulator is written. For store, the memory write and the accumulator drive coincide there. In phase 4 the program-counter increment also falls in the first cycle in which the address register and the instruction register drive. Each instruction code is run with both carry values through a full eight-phase sweep, and every strobe is compared to its expected value in each phase, so these overlaps are judged phase by phase. A mid-run reset and an instruction change between phases are also checked.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
    localparam int PH_W   = 3;
    localparam int OP_W   = 2;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    typedef enum logic [OP_W-1:0] {
        OP_NOR   = 2'b00,
        OP_ADD   = 2'b01,
        OP_STORE = 2'b10,
        OP_JUMP  = 2'b11
    } op_e;

    typedef struct packed {
        logic ram_oe;
        logic ram_we;
        logic pc_oe;
        logic pc_load;
        logic pc_inc;
        logic ar_oe;
        logic ar_we;
        logic ir_oe;
        logic ir_we;
        logic acc_oe;
        logic acc_we;
        logic acc_carry_clr;
        logic alu_oe;
        logic alu_we;
        logic alu_fn;
    } strobe_t;
endpackage

// File: rtl/phase_counter.sv
module phase_counter
    import ctl_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase_d,
    output logic [PH_W-1:0] phase_q
);
    always_comb begin
        phase_d = phase_q + PH_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase_q == PH_W'($past(phase_q) + PH_W'(1)));
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
    import ctl_seq_pkg::*;
(
    input  logic [PH_W-1:0] phase,
    input  logic [OP_W-1:0] op_code,
    input  logic            carry_in,
    output strobe_t         strobe
);
    logic fetch_ph;
    logic alu_cls;
    logic is_store;
    logic is_jump;

    always_comb begin
        fetch_ph = (phase < PH_W'(4));
        alu_cls  = (op_code == OP_NOR) || (op_code == OP_ADD);
        is_store = (op_code == OP_STORE);
        is_jump  = (op_code == OP_JUMP);

        strobe               = '0;
        strobe.pc_oe         = fetch_ph;
        strobe.ar_oe         = !fetch_ph;
        strobe.ir_oe         = !fetch_ph;
        strobe.ram_oe        = fetch_ph ||
                               (alu_cls && (phase == PH_W'(4) || phase == PH_W'(5)));
        strobe.ir_we         = (phase == PH_W'(1));
        strobe.ar_we         = (phase == PH_W'(3));
        strobe.pc_inc        = (phase == PH_W'(2)) || (phase == PH_W'(4));
        strobe.alu_we        = alu_cls && (phase == PH_W'(5));
        strobe.alu_oe        = alu_cls && (phase == PH_W'(5) || phase == PH_W'(6));
        strobe.acc_we        = alu_cls && (phase == PH_W'(6));
        strobe.alu_fn        = op_code[0];
        strobe.acc_oe        = is_store && (phase == PH_W'(5) || phase == PH_W'(6));
        strobe.ram_we        = is_store && (phase == PH_W'(6));
        strobe.pc_load       = is_jump && !carry_in && (phase == PH_W'(5));
        strobe.acc_carry_clr = is_jump && carry_in && (phase == PH_W'(5));
    end
endmodule

// File: rtl/imm_fill.sv
module imm_fill
    import ctl_seq_pkg::*;
(
    input  logic              drive,
    input  logic [NIB_W-1:0]  nibble,
    output logic [DATA_W-1:0] imm
);
    localparam int REPS = DATA_W / NIB_W;

    always_comb begin
        imm = drive ? {REPS{nibble}} : '0;
    end
endmodule

// File: rtl/ctl_phase_seq.sv
module ctl_phase_seq
    import ctl_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_code,
    input  logic              carry_in,
    input  logic [NIB_W-1:0]  ir_nibble,
    output logic [PH_W-1:0]   phase,
    output logic              ram_oe,
    output logic              ram_we,
    output logic              pc_oe,
    output logic              pc_load,
    output logic              pc_inc,
    output logic              ar_oe,
    output logic              ar_we,
    output logic              ir_oe,
    output logic              ir_we,
    output logic              acc_oe,
    output logic              acc_we,
    output logic              acc_carry_clr,
    output logic              alu_oe,
    output logic              alu_we,
    output logic              alu_fn,
    output logic [DATA_W-1:0] imm_byte
);
    logic [PH_W-1:0] phase_d;
    logic [PH_W-1:0] phase_q;
    strobe_t         dec_s;
    strobe_t         strb_d;
    strobe_t         strb_q;

    phase_counter u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_d (phase_d),
        .phase_q (phase_q)
    );

    strobe_decode u_dec (
        .phase    (phase_d),
        .op_code  (op_code),
        .carry_in (carry_in),
        .strobe   (dec_s)
    );

    always_comb begin
        strb_d = dec_s;
    end

    always_ff @(posedge clk) begin
        if (rst) strb_q <= '0;
        else     strb_q <= strb_d;
    end

    imm_fill u_imm (
        .drive  (strb_q.ir_oe),
        .nibble (ir_nibble),
        .imm    (imm_byte)
    );

    assign phase         = phase_q;
    assign ram_oe        = strb_q.ram_oe;
    assign ram_we        = strb_q.ram_we;
    assign pc_oe         = strb_q.pc_oe;
    assign pc_load       = strb_q.pc_load;
    assign pc_inc        = strb_q.pc_inc;
    assign ar_oe         = strb_q.ar_oe;
    assign ar_we         = strb_q.ar_we;
    assign ir_oe         = strb_q.ir_oe;
    assign ir_we         = strb_q.ir_we;
    assign acc_oe        = strb_q.acc_oe;
    assign acc_we        = strb_q.acc_we;
    assign acc_carry_clr = strb_q.acc_carry_clr;
    assign alu_oe        = strb_q.alu_oe;
    assign alu_we        = strb_q.alu_we;
    assign alu_fn        = strb_q.alu_fn;

    // R3
    addr_drv_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pc_oe && ar_oe));
    // R9
    jump_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pc_load && acc_carry_clr));
    // R8
    store_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (acc_oe && !ram_oe));
    // R6
    acc_from_alu_chk: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> alu_oe);
    // R10
    imm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (imm_byte != '0) |-> ir_oe);
    // R5
    fetch_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_we || ar_we) |-> pc_oe);
endmodule

// File: tb/tb_ctl_phase_seq.sv
module tb_ctl_phase_seq;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op_code = 2'b00;
    logic       carry_in = 1'b0;
    logic [3:0] ir_nibble = 4'h0;
    logic [2:0] phase;
    logic ram_oe, ram_we, pc_oe, pc_load, pc_inc, ar_oe, ar_we, ir_oe, ir_we;
    logic acc_oe, acc_we, acc_carry_clr, alu_oe, alu_we, alu_fn;
    logic [7:0] imm_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ctl_phase_seq dut (
        .clk(clk), .rst(rst), .op_code(op_code), .carry_in(carry_in),
        .ir_nibble(ir_nibble), .phase(phase), .ram_oe(ram_oe), .ram_we(ram_we),
        .pc_oe(pc_oe), .pc_load(pc_load), .pc_inc(pc_inc), .ar_oe(ar_oe),
        .ar_we(ar_we), .ir_oe(ir_oe), .ir_we(ir_we), .acc_oe(acc_oe),
        .acc_we(acc_we), .acc_carry_clr(acc_carry_clr), .alu_oe(alu_oe),
        .alu_we(alu_we), .alu_fn(alu_fn), .imm_byte(imm_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, string nm, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, nm, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_quiet(string ctx);
        chk("R1", {ctx, " phase"}, int'(phase), 0);
        chk("R2", {ctx, " strobes"},
            int'({ram_oe, ram_we, pc_oe, pc_load, pc_inc, ar_oe, ar_we, ir_oe,
                  ir_we, acc_oe, acc_we, acc_carry_clr, alu_oe, alu_we, alu_fn}), 0);
        chk("R10", {ctx, " imm"}, int'(imm_byte), 0);
    endtask

    // Expected strobes for phase p, instruction code o, carry c.
    task automatic check_phase(int p, logic [1:0] o, logic c, logic [3:0] nib);
        bit fe = (p < 4);
        bit ac = (o == 2'b00) || (o == 2'b01);
        bit st = (o == 2'b10);
        bit jp = (o == 2'b11);
        chk("R1", "phase", int'(phase), p);
        chk("R3", "pc_oe", int'(pc_oe), int'(fe));
        chk("R3", "ar_oe", int'(ar_oe), int'(!fe));
        chk("R3", "ir_oe", int'(ir_oe), int'(!fe));
        chk("R4", "ram_oe", int'(ram_oe), int'(fe || (ac && (p == 4 || p == 5))));
        chk("R5", "ir_we", int'(ir_we), int'(p == 1));
        chk("R5", "ar_we", int'(ar_we), int'(p == 3));
        chk("R5", "pc_inc", int'(pc_inc), int'(p == 2 || p == 4));
        chk("R6", "alu_we", int'(alu_we), int'(ac && p == 5));
        chk("R6", "alu_oe", int'(alu_oe), int'(ac && (p == 5 || p == 6)));
        chk("R6", "acc_we", int'(acc_we), int'(ac && p == 6));
        chk("R7", "alu_fn", int'(alu_fn), int'(o[0]));
        chk("R8", "acc_oe", int'(acc_oe), int'(st && (p == 5 || p == 6)));
        chk("R8", "ram_we", int'(ram_we), int'(st && p == 6));
        chk("R9", "pc_load", int'(pc_load), int'(jp && !c && p == 5));
        chk("R9", "acc_carry_clr", int'(acc_carry_clr), int'(jp && c && p == 5));
        chk("R10", "imm_byte", int'(imm_byte), fe ? 0 : int'({nib, nib}));
    endtask

    // Full sweep of one code and carry value, starting from reset.
    task automatic t_sweep(logic [1:0] o, logic c, logic [3:0] nib);
        op_code = o;
        carry_in = c;
        ir_nibble = nib;
        do_reset();
        check_quiet("sweep reset");
        rst = 1'b0;
        for (int k = 1; k <= 16; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_phase(k % 8, o, c, nib);
        end
    endtask

    // R1 R2: reset in the middle of a sequence.
    task automatic t_mid_reset();
        op_code = 2'b10;
        carry_in = 1'b0;
        ir_nibble = 4'h3;
        do_reset();
        rst = 1'b0;
        for (int k = 1; k <= 5; k++) @(posedge clk);
        @(negedge clk);
        check_phase(5, 2'b10, 1'b0, 4'h3);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_quiet("mid reset");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_phase(1, 2'b10, 1'b0, 4'h3);
    endtask

    // R9 R7: code and carry change between phases take effect at the next edge.
    task automatic t_late_change();
        op_code = 2'b01;
        carry_in = 1'b0;
        ir_nibble = 4'hC;
        do_reset();
        rst = 1'b0;
        for (int k = 1; k <= 4; k++) @(posedge clk);
        @(negedge clk);
        check_phase(4, 2'b01, 1'b0, 4'hC);
        op_code = 2'b11;
        carry_in = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_phase(5, 2'b11, 1'b1, 4'hC);
        carry_in = 1'b0;
        op_code = 2'b00;
        @(posedge clk);
        @(negedge clk);
        check_phase(6, 2'b00, 1'b0, 4'hC);
    endtask

    initial begin
        for (int o = 0; o < 4; o++) begin
            for (int c = 0; c < 2; c++) begin
                t_sweep(2'(o), 1'(c), 4'(4'h5 + o * 3 + c));
            end
        end
        t_sweep(2'b00, 1'b1, 4'hF);
        t_mid_reset();
        t_late_change();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WDOG_CYCLES; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule